// File: doc/BRIEF.md
# Write-Protect Key Sequencer

This block sits on the path of accepted byte writes into a page-programmed non-volatile store. It watches the first writes of each page load for fixed address/data keys. A key is either a three-step unlock/enable key or a six-step command key whose last data byte selects an action. The actions are: turn software write protection on, turn it off, request a full-array clear, or switch the automatic clear-before-write mode off or back on. Key writes are swallowed. Every other accepted write is passed on to the page buffer as page data.

The page-buffer timing logic tells the block that a load window has closed by pulsing `load_end`. One cycle later the block answers with `commit_go` or `commit_drop`. The answer depends on whether the load held page data and whether protection permits the commit. Protection survives the `pwr_up` pulse, which models a supply cycle; only `rst_n` (device initialisation) clears it. A requested array clear is held on `clr_req` until the array answers `clr_ack`.

The write input is a valid/ready stream. `wr_ready` drops only while an array clear is pending. During that time no write is accepted, and the source must hold `wr_valid` and its address and data. The page-data output is a pass-through of the accepted write with no back-pressure of its own: the page buffer accepts any byte presented on `pg_valid`.

Top module: `wprot_cmd_seq`

## Requirements
- R1: After `rst_n` the block shows protection off, autoclear on, no clear request, `wr_ready` high and no commit pulse.
- R2: While no page byte has yet been accepted in the current load, a write that matches the expected key step is consumed. `pg_valid` stays low in its cycle. The key addresses are 0x5555 (H) and 0x2AAA (L). The steps are 0xAA@H, 0x55@L, then at H either 0xA0 (three-step key, complete) or 0x80 (continue), then 0xAA@H, 0x55@L, and a final command byte at H.
- R3: A write that does not match the expected step abandons the key. That write is passed on as page data (`pg_valid` high), and no command from the abandoned key takes effect.
- R4: One cycle after `load_end` exactly one of two things happens. If the load held page data and either protection is off or the load carried a complete three-step key or disable key, `commit_go` pulses. If the load held page data, protection is on and there was no such key, `commit_drop` pulses. If the load held no page data, neither pulses. A write accepted in the `load_end` cycle belongs to the ending load.
- R5: A three-step key followed by page data in the same load turns protection on; `prot_on` changes one cycle after `load_end`.
- R6: A six-step key with command byte 0x20 followed by page data turns protection off one cycle after `load_end`, and that load's page commits.
- R7: A protection enable or disable key with no page data after it in the same load leaves `prot_on` unchanged.
- R8: Command byte 0x10 raises `clr_req` in the cycle after the final step, whether or not protection is on. `clr_req` stays high until `clr_ack`, and `wr_ready` is low while it is high.
- R9: Command bytes 0x40 and 0x50 clear and set `autoclr_on` in the cycle after the final step, with no page data needed.
- R10: A `pwr_up` pulse sets `autoclr_on`, drops any clear request, discards the current load and restarts key detection, while `prot_on` keeps its value.
- R11: Once a page byte has been accepted in a load, later writes in that load are page data even if they match key steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low device initialisation, clears all state including protection |
| pwr_up | input | 1 | One-cycle supply-cycle pulse, keeps protection |
| wr_valid | input | 1 | Write stream valid |
| wr_ready | output | 1 | Write stream ready, low while a clear is pending |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | DATA_W | Write byte data |
| load_end | input | 1 | Pulse: the current page load window has closed |
| pg_valid | output | 1 | Accepted write is page data for the buffer |
| pg_addr | output | ADDR_W | Page data address |
| pg_data | output | DATA_W | Page data byte |
| commit_go | output | 1 | Pulse: write the loaded page to the array |
| commit_drop | output | 1 | Pulse: discard the loaded page, protection refused it |
| prot_on | output | 1 | Software write protection active |
| autoclr_on | output | 1 | Automatic clear-before-write enabled |
| clr_req | output | 1 | Full-array clear requested, held until acknowledged |
| clr_ack | input | 1 | Array has taken the clear request |

## Verification
Some properties are checked on every cycle. A clear request holds until acknowledged. Commit pulses appear only right after a load end and never both at once. A drop only happens while protected. Protection changes only right after a load end. A supply-cycle pulse restores autoclear and leaves protection alone. Which writes are swallowed, how a wrong step abandons a key, whether a load commits and how each command byte acts depend on whole multi-write scenarios, so only the bench's key sequences and their boundary cases can show them.

// File: rtl/wpcs_pkg.sv
package wpcs_pkg;
  localparam logic [14:0] KEY_ADDR_H = 15'h5555;
  localparam logic [14:0] KEY_ADDR_L = 15'h2AAA;
  localparam logic [7:0]  KEY_D_AA   = 8'hAA;
  localparam logic [7:0]  KEY_D_55   = 8'h55;
  localparam logic [7:0]  KEY_D_PEN  = 8'hA0;  // three-step key end
  localparam logic [7:0]  KEY_D_EXT  = 8'h80;  // continue to six steps
  localparam logic [7:0]  CMD_B_PDIS = 8'h20;
  localparam logic [7:0]  CMD_B_CLR  = 8'h10;
  localparam logic [7:0]  CMD_B_ACOF = 8'h40;
  localparam logic [7:0]  CMD_B_ACON = 8'h50;

  typedef enum logic [2:0] {
    ST_K1, ST_K2, ST_K3, ST_K4, ST_K5, ST_K6, ST_OFF
  } key_st_t;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_UNLOCK, CMD_PDIS, CMD_CLEAR, CMD_ACOFF, CMD_ACON
  } key_cmd_t;
endpackage

// File: rtl/wpcs_key_fsm.sv
module wpcs_key_fsm
  import wpcs_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              fire,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              consumed,
  output key_cmd_t          cmd
);
  localparam logic [ADDR_W-1:0] A_H = ADDR_W'(KEY_ADDR_H);
  localparam logic [ADDR_W-1:0] A_L = ADDR_W'(KEY_ADDR_L);
  localparam logic [DATA_W-1:0] D_AA = DATA_W'(KEY_D_AA);
  localparam logic [DATA_W-1:0] D_55 = DATA_W'(KEY_D_55);
  localparam logic [DATA_W-1:0] D_PEN = DATA_W'(KEY_D_PEN);
  localparam logic [DATA_W-1:0] D_EXT = DATA_W'(KEY_D_EXT);
  localparam logic [DATA_W-1:0] C_PDIS = DATA_W'(CMD_B_PDIS);
  localparam logic [DATA_W-1:0] C_CLR = DATA_W'(CMD_B_CLR);
  localparam logic [DATA_W-1:0] C_ACOF = DATA_W'(CMD_B_ACOF);
  localparam logic [DATA_W-1:0] C_ACON = DATA_W'(CMD_B_ACON);

  key_st_t st, nxt;
  logic at_h, at_l;

  assign at_h = (addr == A_H);
  assign at_l = (addr == A_L);

  always_comb begin
    nxt      = st;
    consumed = 1'b0;
    cmd      = CMD_NONE;
    if (fire && st != ST_OFF) begin
      nxt = ST_OFF;  // any miss abandons the key for this load
      case (st)
        ST_K1: if (at_h && data == D_AA) begin consumed = 1'b1; nxt = ST_K2; end
        ST_K2: if (at_l && data == D_55) begin consumed = 1'b1; nxt = ST_K3; end
        ST_K3: begin
          if (at_h && data == D_PEN) begin
            consumed = 1'b1;
            cmd      = CMD_UNLOCK;
          end else if (at_h && data == D_EXT) begin
            consumed = 1'b1;
            nxt      = ST_K4;
          end
        end
        ST_K4: if (at_h && data == D_AA) begin consumed = 1'b1; nxt = ST_K5; end
        ST_K5: if (at_l && data == D_55) begin consumed = 1'b1; nxt = ST_K6; end
        ST_K6: begin
          if (at_h) begin
            consumed = 1'b1;
            case (data)
              C_PDIS:  cmd = CMD_PDIS;
              C_CLR:   cmd = CMD_CLEAR;
              C_ACOF:  cmd = CMD_ACOFF;
              C_ACON:  cmd = CMD_ACON;
              default: consumed = 1'b0;
            endcase
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       st <= ST_K1;
    else if (restart) st <= ST_K1;
    else              st <= nxt;
  end
endmodule

// File: rtl/wpcs_mode_regs.sv
module wpcs_mode_regs
  import wpcs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pwr_up,
  input  logic     load_end,
  input  logic     data_fire,
  input  key_cmd_t cmd,
  input  logic     clr_ack,
  output logic     prot_on,
  output logic     autoclr_on,
  output logic     clr_req,
  output logic     commit_go,
  output logic     commit_drop
);
  logic data_seen, pend_en, pend_dis, unlocked;
  logic eff_data, eff_en, eff_dis, eff_unl;

  assign eff_data = data_seen | data_fire;
  assign eff_en   = pend_en   | (cmd == CMD_UNLOCK);
  assign eff_dis  = pend_dis  | (cmd == CMD_PDIS);
  assign eff_unl  = unlocked  | (cmd == CMD_UNLOCK) | (cmd == CMD_PDIS);

  // per-load bookkeeping, cleared when the load closes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_seen <= 1'b0; pend_en <= 1'b0; pend_dis <= 1'b0; unlocked <= 1'b0;
    end else if (load_end || pwr_up) begin
      data_seen <= 1'b0; pend_en <= 1'b0; pend_dis <= 1'b0; unlocked <= 1'b0;
    end else begin
      data_seen <= eff_data; pend_en <= eff_en; pend_dis <= eff_dis; unlocked <= eff_unl;
    end
  end

  // protection: only device initialisation clears it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prot_on <= 1'b0;
    else if (load_end && !pwr_up && eff_data) begin
      if (eff_dis)     prot_on <= 1'b0;
      else if (eff_en) prot_on <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || pwr_up) begin
      commit_go   <= 1'b0;
      commit_drop <= 1'b0;
    end else begin
      commit_go   <= load_end && eff_data && (!prot_on || eff_unl);
      commit_drop <= load_end && eff_data && prot_on && !eff_unl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || pwr_up)      autoclr_on <= 1'b1;
    else if (cmd == CMD_ACOFF) autoclr_on <= 1'b0;
    else if (cmd == CMD_ACON)  autoclr_on <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || pwr_up)      clr_req <= 1'b0;
    else if (cmd == CMD_CLEAR) clr_req <= 1'b1;
    else if (clr_ack)          clr_req <= 1'b0;
  end
endmodule

// File: rtl/wprot_cmd_seq.sv
module wprot_cmd_seq
  import wpcs_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_up,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load_end,
  output logic              pg_valid,
  output logic [ADDR_W-1:0] pg_addr,
  output logic [DATA_W-1:0] pg_data,
  output logic              commit_go,
  output logic              commit_drop,
  output logic              prot_on,
  output logic              autoclr_on,
  output logic              clr_req,
  input  logic              clr_ack
);
  logic     fire, consumed;
  key_cmd_t cmd;

  assign wr_ready = !clr_req;
  assign fire     = wr_valid && wr_ready;
  assign pg_valid = fire && !consumed;
  assign pg_addr  = wr_addr;
  assign pg_data  = wr_data;

  wpcs_key_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_keys (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (load_end | pwr_up),
    .fire     (fire),
    .addr     (wr_addr),
    .data     (wr_data),
    .consumed (consumed),
    .cmd      (cmd)
  );

  wpcs_mode_regs u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_up      (pwr_up),
    .load_end    (load_end),
    .data_fire   (pg_valid),
    .cmd         (cmd),
    .clr_ack     (clr_ack),
    .prot_on     (prot_on),
    .autoclr_on  (autoclr_on),
    .clr_req     (clr_req),
    .commit_go   (commit_go),
    .commit_drop (commit_drop)
  );
endmodule

// File: rtl/wpcs_chk.sv
module wpcs_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_up,
  input logic load_end,
  input logic wr_valid,
  input logic wr_ready,
  input logic pg_valid,
  input logic commit_go,
  input logic commit_drop,
  input logic prot_on,
  input logic autoclr_on,
  input logic clr_req,
  input logic clr_ack
);
  // R8
  clr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req && !clr_ack && !pwr_up |=> clr_req);
  // R8
  clr_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |-> !pg_valid);
  // R2
  pg_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pg_valid |-> (wr_valid && wr_ready));
  // R4
  commit_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_go || commit_drop) |-> $past(load_end));
  // R4
  commit_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_go && commit_drop));
  // R4
  drop_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_drop |-> prot_on);
  // R5
  prot_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prot_on) |-> $past(load_end));
  // R10
  pwr_autoclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_up |=> (autoclr_on && !clr_req));
  // R10
  pwr_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_up |=> $stable(prot_on));
endmodule

bind wprot_cmd_seq wpcs_chk u_chk (.*);

// File: tb/test_wprot_cmd_seq.sv
module test_wprot_cmd_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0, pwr_up = 1'b0, wr_valid = 1'b0, load_end = 1'b0, clr_ack = 1'b0;
  logic [14:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic wr_ready, pg_valid, commit_go, commit_drop, prot_on, autoclr_on, clr_req;
  logic [14:0] pg_addr;
  logic [7:0]  pg_data;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  wprot_cmd_seq i_wprot_cmd_seq (
    .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .load_end(load_end), .pg_valid(pg_valid),
    .pg_addr(pg_addr), .pg_data(pg_data), .commit_go(commit_go), .commit_drop(commit_drop),
    .prot_on(prot_on), .autoclr_on(autoclr_on), .clr_req(clr_req), .clr_ack(clr_ack));

  // [26] load end, [25:11] addr, [10:3] data, [2] keep / go, [1] drop, [0] prot after end
  localparam int NV = 28;
  localparam logic [26:0] VEC [0:NV-1] = '{
    {1'b0, 15'h0100, 8'h11, 3'b100},  // plain data, unprotected
    {1'b1, 15'h0000, 8'h00, 3'b100},  // R4 commits
    {1'b0, 15'h5555, 8'hAA, 3'b000},  // R2 key steps swallowed
    {1'b0, 15'h2AAA, 8'h55, 3'b000},
    {1'b0, 15'h5555, 8'hA0, 3'b000},
    {1'b0, 15'h0200, 8'h22, 3'b100},
    {1'b1, 15'h0000, 8'h00, 3'b101},  // R5 protection on
    {1'b0, 15'h0300, 8'h33, 3'b100},
    {1'b1, 15'h0000, 8'h00, 3'b011},  // R4 drop while protected
    {1'b0, 15'h5555, 8'hAA, 3'b000},
    {1'b0, 15'h2AAA, 8'h55, 3'b000},
    {1'b0, 15'h5555, 8'hA0, 3'b000},
    {1'b0, 15'h0301, 8'h44, 3'b100},
    {1'b1, 15'h0000, 8'h00, 3'b101},  // R4 unlocked load commits
    {1'b0, 15'h5555, 8'hAA, 3'b000},
    {1'b0, 15'h2AAA, 8'h56, 3'b100},  // R3 wrong byte passes as data
    {1'b0, 15'h0302, 8'h66, 3'b100},
    {1'b1, 15'h0000, 8'h00, 3'b011},  // R3 abandoned key: drop
    {1'b0, 15'h5555, 8'hAA, 3'b000},
    {1'b0, 15'h2AAA, 8'h55, 3'b000},
    {1'b0, 15'h5555, 8'h80, 3'b000},
    {1'b0, 15'h5555, 8'hAA, 3'b000},
    {1'b0, 15'h2AAA, 8'h55, 3'b000},
    {1'b0, 15'h5555, 8'h20, 3'b000},
    {1'b0, 15'h0400, 8'h77, 3'b100},
    {1'b1, 15'h0000, 8'h00, 3'b100},  // R6 protection off, commits
    {1'b0, 15'h0500, 8'h88, 3'b100},
    {1'b1, 15'h0000, 8'h00, 3'b100}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [14:0] a, input logic [7:0] d, input logic keep, input string req);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    #1;
    chk(req, {31'd0, pg_valid}, {31'd0, keep});
    if (keep) chk(req, {9'd0, pg_addr, pg_data}, {9'd0, a, d});
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic endl(input logic go, input logic drop, input string req);
    @(negedge clk);
    load_end = 1'b1;
    @(posedge clk); #1;
    load_end = 1'b0;
    @(negedge clk);
    chk(req, {30'd0, commit_go, commit_drop}, {30'd0, go, drop});
  endtask

  task automatic key_pre;
    wr(15'h5555, 8'hAA, 1'b0, "R2");
    wr(15'h2AAA, 8'h55, 1'b0, "R2");
  endtask

  task automatic key6(input logic [7:0] c);
    key_pre();
    wr(15'h5555, 8'h80, 1'b0, "R2");
    key_pre();
    wr(15'h5555, c, 1'b0, "R2");
  endtask

  task automatic report;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", {26'd0, prot_on, autoclr_on, clr_req, wr_ready, commit_go, commit_drop},
              {26'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0});

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][26]) begin
        endl(VEC[i][2], VEC[i][1], "R4");
        chk("R5/R6", {31'd0, prot_on}, {31'd0, VEC[i][0]});
      end else begin
        wr(VEC[i][25:11], VEC[i][10:3], VEC[i][2], "R2/R3");
      end
    end

    // R7 enable key without page data has no effect
    key_pre();
    wr(15'h5555, 8'hA0, 1'b0, "R7");
    endl(1'b0, 1'b0, "R7");
    chk("R7", {31'd0, prot_on}, 32'd0);

    // R11 key bytes after page data are plain data
    wr(15'h0600, 8'h99, 1'b1, "R11");
    wr(15'h5555, 8'hAA, 1'b1, "R11");
    wr(15'h2AAA, 8'h55, 1'b1, "R11");
    wr(15'h5555, 8'hA0, 1'b1, "R11");
    endl(1'b1, 1'b0, "R11");
    chk("R11", {31'd0, prot_on}, 32'd0);

    // R3 unknown sixth byte abandons the key
    key_pre();
    wr(15'h5555, 8'h80, 1'b0, "R3");
    key_pre();
    wr(15'h5555, 8'h30, 1'b1, "R3");
    endl(1'b1, 1'b0, "R3");
    chk("R3", {30'd0, prot_on, autoclr_on}, {30'd0, 1'b0, 1'b1});

    // R9 autoclear off without page data
    key6(8'h40);
    @(negedge clk);
    chk("R9", {31'd0, autoclr_on}, 32'd0);
    endl(1'b0, 1'b0, "R9");
    chk("R9", {31'd0, autoclr_on}, 32'd0);

    // R5 protect again, then R10 supply cycle keeps it
    key_pre();
    wr(15'h5555, 8'hA0, 1'b0, "R5");
    wr(15'h0700, 8'h01, 1'b1, "R5");
    endl(1'b1, 1'b0, "R5");
    chk("R5", {31'd0, prot_on}, 32'd1);
    @(negedge clk);
    pwr_up = 1'b1;
    @(posedge clk); #1;
    pwr_up = 1'b0;
    @(negedge clk);
    chk("R10", {29'd0, prot_on, autoclr_on, clr_req}, {29'd0, 1'b1, 1'b1, 1'b0});

    // R9 off then on
    key6(8'h40);
    @(negedge clk);
    chk("R9", {31'd0, autoclr_on}, 32'd0);
    endl(1'b0, 1'b0, "R9");
    key6(8'h50);
    @(negedge clk);
    chk("R9", {31'd0, autoclr_on}, 32'd1);
    endl(1'b0, 1'b0, "R9");

    // R8 clear while protected, held until acknowledged
    key6(8'h10);
    @(negedge clk);
    chk("R8", {30'd0, clr_req, wr_ready}, {30'd0, 1'b1, 1'b0});
    repeat (3) @(negedge clk);
    chk("R8", {31'd0, clr_req}, 32'd1);
    clr_ack = 1'b1;
    @(posedge clk); #1;
    clr_ack = 1'b0;
    @(negedge clk);
    chk("R8", {30'd0, clr_req, wr_ready}, {30'd0, 1'b0, 1'b1});
    endl(1'b0, 1'b0, "R8");
    chk("R8", {31'd0, prot_on}, 32'd1);

    report();
  end
endmodule